// File: doc/BRIEF.md
# Microcode Patch Redirect Sequencer

This block is the fetch front end of a microcode sequencer. It holds a microcode instruction pointer and issues one micro-operation word per advance request. Words come from a fixed read-only store for low addresses and from a small writable patch store for addresses at or above a patch base. Together the two form one flat address space, so patch code can be entered by a jump and can hand control back to read-only code the same way.

A small table of breakpoint entries sits beside the pointer. Each entry holds a valid bit, an address to watch for, and a destination. All valid entries are compared with the pointer in parallel on every advance. On a hit the word at the watched address is dropped. The pointer is loaded with the destination of the lowest-numbered hitting entry, and that redirect costs exactly one issue slot. Firmware fills the patch store and the table through two write ports. Each issued word carries an even-parity bit that is checked on the way out.

Top module: `useq_patch_seq`

## Requirements
- R1: After reset the pointer is 0, `uop_valid_o`, `redirect_o` and `par_err_o` are low, every table entry is invalid and every patch word reads as zero. Until an entry is programmed, advancing issues only read-only words.
- R2: When `step_i` is high, `jump_i` is low and no entry hits, the next cycle shows `uop_valid_o` high, `uop_addr_o` equal to the old pointer and `uop_o` equal to the word stored there, and the pointer has advanced by one. With default widths the read-only word at address a is bits [15:8] = a XOR 0xA5, bits [7:0] = a, and bit 16 = even parity over bits [15:0].
- R3: An entry whose valid bit is clear never redirects, whatever its watched address holds.
- R4: When `step_i` is high and a valid entry's watched address equals the pointer, no word is issued in the next cycle. In that cycle `uop_valid_o` is low and `redirect_o` is high, and the pointer equals that entry's destination. The next advance fetches at the destination.
- R5: When several valid entries hit, the destination of the lowest-numbered one is taken.
- R6: Pointer values below 192 read the read-only store. Values 192 to 251 read patch word (value − 192). Values 252 to 255 read an all-zero word.
- R7: A patch write with `pr_addr_i` of 60 or more changes nothing. An advance that reads the patch location being written in the same cycle issues the old contents.
- R8: A table write changes redirection starting with the advance in the cycle after the write. An advance in the same cycle as the write still uses the old entry.
- R9: `par_err_o` is high exactly in the cycles where `uop_valid_o` is high and the 17 bits of `uop_o` hold an odd number of ones.
- R10: `jump_i` loads the pointer with `jump_addr_i` and takes priority over `step_i` and over any hit. No word is issued in the following cycle.
- R11: With `step_i` and `jump_i` both low, the pointer holds and no word is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_i | input | 1 | Issue the word at the pointer and advance |
| jump_i | input | 1 | Load the pointer from `jump_addr_i` |
| jump_addr_i | input | 8 | Jump target |
| mt_we_i | input | 1 | Write one table entry |
| mt_idx_i | input | 2 | Entry number to write |
| mt_valid_i | input | 1 | Valid bit written into the entry |
| mt_match_i | input | 8 | Watched address written into the entry |
| mt_dest_i | input | 8 | Destination written into the entry |
| pr_we_i | input | 1 | Write one patch word |
| pr_addr_i | input | 6 | Patch word index |
| pr_data_i | input | 17 | Patch word, parity in bit 16 |
| uip_o | output | 8 | Current pointer |
| uop_valid_o | output | 1 | A word is issued this cycle |
| uop_addr_o | output | 8 | Address the issued word came from |
| uop_o | output | 17 | Issued word, parity in bit 16 |
| redirect_o | output | 1 | The last advance was redirected by the table |
| par_err_o | output | 1 | The issued word has odd parity |

## Verification
A stale or corrupted table entry shows on the very next advance at the watched address. A missing bubble, or an extra one, appears in `uop_valid_o` and `redirect_o`, and a wrong destination shows in `uip_o` and in the following word's address tag. A wrong read/write ordering in the patch store, or a bad address split, shows in `uop_o` one cycle after the advance that read it. Parity faults show in `par_err_o` in the same cycle as the word they belong to.

// File: rtl/useq_pkg.sv
package useq_pkg;

   typedef enum logic [1:0] {
      SRC_ROM   = 2'd0,
      SRC_PATCH = 2'd1,
      SRC_NONE  = 2'd2
   } fetch_src_e;

   // Fixed image of the read-only store: upper field is the address
   // XOR 0xA5, lower field is the address itself.
   function automatic logic [31:0] rom_pattern(input logic [31:0] addr,
                                               input int unsigned aw);
      return ((addr ^ 32'h0000_00A5) << aw) | addr;
   endfunction

endpackage

// File: rtl/useq_rom.sv
module useq_rom #(
   parameter int unsigned UIP_W = 8,
   parameter int unsigned UOP_W = 16,
   parameter int unsigned DEPTH = 192
) (
   input  logic [UIP_W-1:0] addr_i,
   output logic [UOP_W:0]   word_o
);
   import useq_pkg::*;

   localparam int unsigned WORD_W = UOP_W + 1;

   logic [WORD_W-1:0] image [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_word
      logic [31:0]      pat;
      logic [UOP_W-1:0] dat;
      assign pat = rom_pattern(32'(g), UIP_W);
      assign dat = pat[UOP_W-1:0];
      assign image[g] = {^dat, dat};
   end

   always_comb begin
      if (32'(addr_i) < DEPTH) word_o = image[addr_i];
      else                     word_o = '0;
   end

endmodule

// File: rtl/useq_patch_ram.sv
module useq_patch_ram #(
   parameter int unsigned WORD_W = 17,
   parameter int unsigned DEPTH  = 60,
   parameter int unsigned WA_W   = 6,
   parameter int unsigned RA_W   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic [WA_W-1:0]   waddr_i,
   input  logic [WORD_W-1:0] wdata_i,
   input  logic [RA_W-1:0]   raddr_i,
   output logic [WORD_W-1:0] rdata_o
);

   logic [WORD_W-1:0] mem_q [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_cell
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                              mem_q[g] <= '0;
         else if (we_i && 32'(waddr_i) == 32'(g)) mem_q[g] <= wdata_i;
      end
   end

   // Asynchronous read: a same-cycle write lands only at the edge,
   // so the reader sees the old contents.
   always_comb begin
      if (32'(raddr_i) < DEPTH) rdata_o = mem_q[raddr_i];
      else                      rdata_o = '0;
   end

endmodule

// File: rtl/useq_match_table.sv
module useq_match_table #(
   parameter int unsigned N_ENT = 4,
   parameter int unsigned UIP_W = 8,
   localparam int unsigned IDX_W = $clog2(N_ENT)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we_i,
   input  logic [IDX_W-1:0] idx_i,
   input  logic             valid_i,
   input  logic [UIP_W-1:0] match_i,
   input  logic [UIP_W-1:0] dest_i,
   input  logic [UIP_W-1:0] uip_i,
   output logic             hit_o,
   output logic [UIP_W-1:0] hit_dest_o,
   output logic [N_ENT-1:0] grant_o
);

   logic [N_ENT-1:0] vld_q;
   logic [UIP_W-1:0] mat_q [N_ENT];
   logic [UIP_W-1:0] dst_q [N_ENT];
   logic [N_ENT-1:0] cmp;

   for (genvar g = 0; g < N_ENT; g++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld_q[g] <= 1'b0;
            mat_q[g] <= '0;
            dst_q[g] <= '0;
         end else if (we_i && 32'(idx_i) == 32'(g)) begin
            vld_q[g] <= valid_i;
            mat_q[g] <= match_i;
            dst_q[g] <= dest_i;
         end
      end
      assign cmp[g] = vld_q[g] && (mat_q[g] == uip_i);
   end

   // Walk from the top entry down so the lowest hitting index wins.
   always_comb begin
      grant_o    = '0;
      hit_o      = 1'b0;
      hit_dest_o = '0;
      for (int i = N_ENT - 1; i >= 0; i--) begin
         if (cmp[i]) begin
            grant_o    = '0;
            grant_o[i] = 1'b1;
            hit_o      = 1'b1;
            hit_dest_o = dst_q[i];
         end
      end
   end

endmodule

// File: rtl/useq_patch_seq.sv
module useq_patch_seq #(
   parameter int unsigned UIP_W       = 8,
   parameter int unsigned UOP_W       = 16,
   parameter int unsigned N_MATCH     = 4,
   parameter int unsigned PATCH_BASE  = 192,
   parameter int unsigned PATCH_DEPTH = 60,
   localparam int unsigned IDX_W  = $clog2(N_MATCH),
   localparam int unsigned PR_AW  = $clog2(PATCH_DEPTH),
   localparam int unsigned WORD_W = UOP_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step_i,
   input  logic              jump_i,
   input  logic [UIP_W-1:0]  jump_addr_i,
   input  logic              mt_we_i,
   input  logic [IDX_W-1:0]  mt_idx_i,
   input  logic              mt_valid_i,
   input  logic [UIP_W-1:0]  mt_match_i,
   input  logic [UIP_W-1:0]  mt_dest_i,
   input  logic              pr_we_i,
   input  logic [PR_AW-1:0]  pr_addr_i,
   input  logic [WORD_W-1:0] pr_data_i,
   output logic [UIP_W-1:0]  uip_o,
   output logic              uop_valid_o,
   output logic [UIP_W-1:0]  uop_addr_o,
   output logic [WORD_W-1:0] uop_o,
   output logic              redirect_o,
   output logic              par_err_o
);
   import useq_pkg::*;

   localparam logic [UIP_W-1:0] BASE_A = UIP_W'(PATCH_BASE);
   localparam int unsigned      TOP    = PATCH_BASE + PATCH_DEPTH;

   initial begin
      if (N_MATCH < 2)                 $fatal(1, "N_MATCH must be at least 2");
      if (UOP_W < UIP_W || UOP_W > 32) $fatal(1, "UOP_W out of range");
      if (TOP > (1 << UIP_W))          $fatal(1, "patch window exceeds pointer range");
   end

   logic [UIP_W-1:0]  uip_q;
   logic              hit;
   logic [UIP_W-1:0]  hit_dest;
   logic [N_MATCH-1:0] hit_vec;
   logic [WORD_W-1:0] rom_word, patch_word, fetch_word;
   logic [UIP_W-1:0]  patch_idx;
   fetch_src_e        src;

   useq_match_table #(.N_ENT(N_MATCH), .UIP_W(UIP_W)) u_table (
      .clk, .rst_n,
      .we_i(mt_we_i), .idx_i(mt_idx_i), .valid_i(mt_valid_i),
      .match_i(mt_match_i), .dest_i(mt_dest_i),
      .uip_i(uip_q), .hit_o(hit), .hit_dest_o(hit_dest), .grant_o(hit_vec)
   );

   useq_rom #(.UIP_W(UIP_W), .UOP_W(UOP_W), .DEPTH(PATCH_BASE)) u_rom (
      .addr_i(uip_q), .word_o(rom_word)
   );

   assign patch_idx = uip_q - BASE_A;

   useq_patch_ram #(.WORD_W(WORD_W), .DEPTH(PATCH_DEPTH), .WA_W(PR_AW), .RA_W(UIP_W)) u_patch (
      .clk, .rst_n,
      .we_i(pr_we_i), .waddr_i(pr_addr_i), .wdata_i(pr_data_i),
      .raddr_i(patch_idx), .rdata_o(patch_word)
   );

   always_comb begin
      if (uip_q < BASE_A)           src = SRC_ROM;
      else if (32'(uip_q) < TOP)    src = SRC_PATCH;
      else                          src = SRC_NONE;
      unique case (src)
         SRC_ROM:   fetch_word = rom_word;
         SRC_PATCH: fetch_word = patch_word;
         default:   fetch_word = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         uip_q       <= '0;
         uop_valid_o <= 1'b0;
         uop_addr_o  <= '0;
         uop_o       <= '0;
         redirect_o  <= 1'b0;
         par_err_o   <= 1'b0;
      end else begin
         uop_valid_o <= 1'b0;
         redirect_o  <= 1'b0;
         par_err_o   <= 1'b0;
         if (jump_i) begin
            uip_q <= jump_addr_i;
         end else if (step_i && hit) begin
            uip_q      <= hit_dest;
            redirect_o <= 1'b1;
         end else if (step_i) begin
            uip_q       <= uip_q + 1'b1;
            uop_valid_o <= 1'b1;
            uop_addr_o  <= uip_q;
            uop_o       <= fetch_word;
            par_err_o   <= ^fetch_word;
         end
      end
   end

   assign uip_o = uip_q;

endmodule

// File: rtl/useq_patch_seq_chk.sv
module useq_patch_seq_chk #(
   parameter int unsigned UIP_W   = 8,
   parameter int unsigned WORD_W  = 17,
   parameter int unsigned N_MATCH = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               step_i,
   input logic               jump_i,
   input logic [UIP_W-1:0]   jump_addr_i,
   input logic [UIP_W-1:0]   uip_o,
   input logic               uop_valid_o,
   input logic [UIP_W-1:0]   uop_addr_o,
   input logic [WORD_W-1:0]  uop_o,
   input logic               redirect_o,
   input logic               par_err_o,
   input logic               hit,
   input logic [UIP_W-1:0]   hit_dest,
   input logic [N_MATCH-1:0] hit_vec
);

   p_reset_idle_r1: assert property (@(posedge clk)
      $rose(rst_n) |-> (!uop_valid_o && !redirect_o && !par_err_o && uip_o == '0));

   p_step_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !jump_i && !hit) |=>
         (uop_valid_o && uop_addr_o == $past(uip_o)
          && uip_o == UIP_W'($past(uip_o) + 1'b1)));

   p_redirect_bubble_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !jump_i && hit) |=>
         (!uop_valid_o && redirect_o && uip_o == $past(hit_dest)));

   p_single_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec));

   p_err_with_word_r9: assert property (@(posedge clk) disable iff (!rst_n)
      par_err_o |-> uop_valid_o);

   p_jump_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
      jump_i |=> (uip_o == $past(jump_addr_i) && !uop_valid_o && !redirect_o));

   p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!step_i && !jump_i) |=> ($stable(uip_o) && !uop_valid_o));

endmodule

bind useq_patch_seq useq_patch_seq_chk #(
   .UIP_W(UIP_W), .WORD_W(WORD_W), .N_MATCH(N_MATCH)
) u_chk (
   .clk(clk), .rst_n(rst_n), .step_i(step_i), .jump_i(jump_i),
   .jump_addr_i(jump_addr_i), .uip_o(uip_o), .uop_valid_o(uop_valid_o),
   .uop_addr_o(uop_addr_o), .uop_o(uop_o), .redirect_o(redirect_o),
   .par_err_o(par_err_o), .hit(hit), .hit_dest(hit_dest), .hit_vec(hit_vec)
);

// File: tb/test_useq_patch_seq.sv
`timescale 1ns/1ps
module test_useq_patch_seq;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        step_i = 1'b0, jump_i = 1'b0;
   logic [7:0]  jump_addr_i = '0;
   logic        mt_we_i = 1'b0, mt_valid_i = 1'b0;
   logic [1:0]  mt_idx_i = '0;
   logic [7:0]  mt_match_i = '0, mt_dest_i = '0;
   logic        pr_we_i = 1'b0;
   logic [5:0]  pr_addr_i = '0;
   logic [16:0] pr_data_i = '0;
   logic [7:0]  uip_o, uop_addr_o;
   logic        uop_valid_o, redirect_o, par_err_o;
   logic [16:0] uop_o;

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   useq_patch_seq i_useq_patch_seq (
      .clk, .rst_n, .step_i, .jump_i, .jump_addr_i,
      .mt_we_i, .mt_idx_i, .mt_valid_i, .mt_match_i, .mt_dest_i,
      .pr_we_i, .pr_addr_i, .pr_data_i,
      .uip_o, .uop_valid_o, .uop_addr_o, .uop_o, .redirect_o, .par_err_o
   );

   localparam logic [7:0] ROM_VEC [8] = '{8'd0, 8'd1, 8'd37, 8'd100,
                                          8'd191, 8'd128, 8'd15, 8'd64};

   function automatic logic [16:0] good(input logic [15:0] d);
      return {^d, d};
   endfunction

   function automatic logic [16:0] rom_exp(input logic [7:0] a);
      return good({a ^ 8'hA5, a});
   endfunction

   task automatic check(input bit ok, input string req,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic jump(input logic [7:0] a);
      jump_i = 1'b1; jump_addr_i = a;
      tick();
      jump_i = 1'b0;
   endtask

   task automatic step();
      step_i = 1'b1;
      tick();
      step_i = 1'b0;
   endtask

   task automatic prog(input logic [1:0] idx, input logic v,
                       input logic [7:0] m, input logic [7:0] d);
      mt_we_i = 1'b1; mt_idx_i = idx; mt_valid_i = v; mt_match_i = m; mt_dest_i = d;
      tick();
      mt_we_i = 1'b0;
   endtask

   task automatic pwrite(input logic [5:0] a, input logic [16:0] d);
      pr_we_i = 1'b1; pr_addr_i = a; pr_data_i = d;
      tick();
      pr_we_i = 1'b0;
   endtask

   task automatic expect_word(input string req, input logic [7:0] a,
                              input logic [16:0] w);
      check(uop_valid_o == 1'b1, req, 32'(uop_valid_o), 32'd1);
      check(uop_addr_o == a, req, 32'(uop_addr_o), 32'(a));
      check(uop_o == w, req, 32'(uop_o), 32'(w));
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      tick(); tick();
      // R1: reset state
      check(uip_o == 8'd0, "R1 uip", 32'(uip_o), 0);
      check(!uop_valid_o && !redirect_o && !par_err_o, "R1 flags",
            32'({uop_valid_o, redirect_o, par_err_o}), 0);
      rst_n = 1'b1;
      tick();
      step();
      expect_word("R1 rom after reset", 8'd0, rom_exp(8'd0));

      // R2: table of read-only addresses
      for (int k = 0; k < 8; k++) begin
         jump(ROM_VEC[k]);
         step();
         expect_word("R2 rom word", ROM_VEC[k], rom_exp(ROM_VEC[k]));
         check(uip_o == ROM_VEC[k] + 8'd1, "R2 advance", 32'(uip_o), 32'(ROM_VEC[k] + 8'd1));
         check(!par_err_o, "R9 clean rom", 32'(par_err_o), 0);
      end

      // R11: idle hold
      tick();
      check(!uop_valid_o && uip_o == ROM_VEC[7] + 8'd1, "R11 hold",
            32'({uop_valid_o, uip_o}), 32'(ROM_VEC[7] + 8'd1));

      // R10: jump beats step
      step_i = 1'b1; jump_i = 1'b1; jump_addr_i = 8'd20;
      tick();
      step_i = 1'b0; jump_i = 1'b0;
      check(!uop_valid_o && uip_o == 8'd20, "R10 jump priority",
            32'({uop_valid_o, uip_o}), 32'd20);

      // patch contents
      pwrite(6'd0, good(16'h1111));
      pwrite(6'd1, good(16'h2203));
      pwrite(6'd2, good(16'h3307));
      pwrite(6'd3, good(16'h440F));

      // R4 / R6: redirect from 50 into patch word 0
      prog(2'd1, 1'b1, 8'd50, 8'd192);
      jump(8'd49);
      step();
      expect_word("R4 pre-hit", 8'd49, rom_exp(8'd49));
      step();
      check(!uop_valid_o && redirect_o, "R4 bubble", 32'({uop_valid_o, redirect_o}), 32'd1);
      check(uip_o == 8'd192, "R4 dest", 32'(uip_o), 32'd192);
      step();
      expect_word("R6 patch 0", 8'd192, good(16'h1111));
      step();
      expect_word("R6 patch 1", 8'd193, good(16'h2203));

      // R3: invalid entry never hits
      prog(2'd0, 1'b0, 8'd60, 8'd195);
      jump(8'd60);
      step();
      expect_word("R3 invalid entry", 8'd60, rom_exp(8'd60));

      // R5: two hits, lower index wins
      prog(2'd2, 1'b1, 8'd70, 8'd193);
      prog(2'd3, 1'b1, 8'd70, 8'd195);
      jump(8'd70);
      step();
      check(uip_o == 8'd193, "R5 priority", 32'(uip_o), 32'd193);

      // R6: destination back in read-only space, and unmapped range
      prog(2'd0, 1'b1, 8'd80, 8'd10);
      jump(8'd80);
      step();
      check(uip_o == 8'd10, "R6 rom dest", 32'(uip_o), 32'd10);
      step();
      expect_word("R6 rom after redirect", 8'd10, rom_exp(8'd10));
      jump(8'd253);
      step();
      expect_word("R6 unmapped", 8'd253, 17'h0);

      // R7: out-of-range patch write ignored; read-before-write
      pwrite(6'd60, good(16'hBEEF));
      jump(8'd252);
      step();
      expect_word("R7 ignored write", 8'd252, 17'h0);
      jump(8'd194);
      step_i = 1'b1; pr_we_i = 1'b1; pr_addr_i = 6'd2; pr_data_i = good(16'h5A5A);
      tick();
      step_i = 1'b0; pr_we_i = 1'b0;
      expect_word("R7 old data", 8'd194, good(16'h3307));
      jump(8'd194);
      step();
      expect_word("R7 new data", 8'd194, good(16'h5A5A));

      // R8: table write lands after the same-cycle advance
      jump(8'd90);
      step_i = 1'b1;
      mt_we_i = 1'b1; mt_idx_i = 2'd2; mt_valid_i = 1'b1; mt_match_i = 8'd90; mt_dest_i = 8'd196;
      tick();
      step_i = 1'b0; mt_we_i = 1'b0;
      expect_word("R8 same cycle", 8'd90, rom_exp(8'd90));
      jump(8'd90);
      step();
      check(redirect_o && uip_o == 8'd196, "R8 next cycle",
            32'({redirect_o, uip_o}), 32'h1C4);

      // R9: bad parity flagged for one word only
      pwrite(6'd5, {1'b0, 16'h0001});
      jump(8'd197);
      step();
      check(par_err_o && uop_valid_o, "R9 bad parity", 32'({par_err_o, uop_valid_o}), 32'd3);
      check(uop_o == 17'h00001, "R9 bad word", 32'(uop_o), 32'h1);
      step();
      check(!par_err_o && uop_valid_o, "R9 flag one cycle",
            32'({par_err_o, uop_valid_o}), 32'd1);

      finish_run();
   end

endmodule